// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register Unit

This block is the register unit of an I/O interrupt redirection controller. Software sees only two bus locations: an 8-bit select register and a 32-bit data window. The value in the select register decides what the window reaches. It can reach a 4-bit controller identifier, a read-only version word, an arbitration word that mirrors the identifier, or one 32-bit half of a 64-bit redirection entry. There is one redirection entry for each interrupt input pin.

The whole redirection table is presented in parallel to the neighbouring delivery logic. Each entry carries an interrupt vector, a delivery mode, a destination mode, a delivery status bit, a polarity bit, a trigger mode, a mask, a remote-IRR status bit and an 8-bit destination. The delivery logic sets the remote-IRR bits through a per-pin strobe. The unit reports two kinds of event to its neighbours, each as a one-cycle pulse per pin: a table write, and a change of an entry's mask bit. Reads are combinational on a single-cycle port that has a valid strobe. Writes take effect at the clock edge that ends the access cycle.

Top module: `redir_regfile`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, every entry reads as 0x0000_0000_0001_0000 on the table output, which means only mask bit 16 is set. The select register reads zero, the identifier is zero, and no pulse is active.
- R2: Only bus offset 0x00 (select) and offset 0x10 (window) respond. A read at any other offset returns zero, and a write at any other offset changes nothing.
- R3: A write to offset 0x00 keeps bits 7:0 of the write data. A read of offset 0x00 returns that byte zero-extended.
- R4: With select 0x01, a window read returns the pin count minus one (0x17) in bits 23:16, the version code 0x11 in bits 7:0, and zero in all other bits. Window writes with this select are ignored.
- R5: With select 0x00, a window write stores data bits 27:24 as the identifier. Window reads with select 0x00 or select 0x02 return the identifier in bits 27:24 and zero in all other bits. Window writes with select 0x02 are ignored.
- R6: A select value S of 0x10 or more addresses entry (S-0x10)>>1. An even S reaches entry bits 31:0 and an odd S reaches bits 63:32. A window read returns that half. A window write replaces that half.
- R7: Window reads with a select of 0x03 to 0x0F, or with a select whose entry index is 24 or more, return 0xFFFF_FFFF. Window writes with those selects change nothing.
- R8: A write to the lower half of an entry forces its remote-IRR bit (bit 14) to zero, whatever the write data holds in that bit. A write to the upper half leaves bit 14 unchanged.
- R9: When remoteIrrSet[i] is high in a cycle, bit 14 of entry i is set at the end of that cycle. The exception is a lower-half write to entry i in the same cycle: the write wins and the bit ends up zero.
- R10: maskChange[i] is high for exactly the one cycle that follows a window write to entry i which changed the entry's mask bit (bit 16). At all other times it is low.
- R11: tableWrite[i] is high for exactly the one cycle that follows any window write to entry i, whether the write targets the lower half or the upper half and whether or not the data changed.
- R12: busRdata is zero in every cycle that is not a read (busValid high and busWrite low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Access strobe for the register port |
| busWrite | input | 1 | 1 selects a write, 0 selects a read |
| busAddr | input | 8 | Byte offset inside the decoded window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| remoteIrrSet | input | 24 | Per-pin strobe from the delivery logic that sets remote-IRR |
| tableFlat | output | 1536 | All entries packed together, entry i in bits [64*i+63 : 64*i] |
| maskChange | output | 24 | One-cycle pulse per pin when a write flipped its mask |
| tableWrite | output | 24 | One-cycle pulse per pin when its entry was written |

## Verification
A wrong select register or index decode makes the window reach the wrong entry half. The table output then shows the corruption in the cycle right after the bad write, on a pin that should not have moved and with a tableWrite pulse on the wrong pin. A stale identifier or a wrong out-of-range decision shows up on busRdata in the very next read cycle, because the read path holds no register. A wrong remote-IRR or mask bit shows on the table output, and on maskChange, one cycle after the cause. The bench compares all outputs against its model in every cycle, so any divergence is reported in the cycle where it first appears.

// File: rtl/redir_pkg.sv
package redir_pkg;

  // Width of the select register and of the entry index derived from it.
  localparam int SEL_W = 8;
  localparam int IDX_W = SEL_W - 1;
  localparam int ENTRY_W = 64;
  localparam int HALF_W = 32;

  typedef struct packed {
    logic [7:0]  dest;
    logic [38:0] rsvd;
    logic        mask;
    logic        trig;
    logic        rirr;
    logic        pol;
    logic        dstat;
    logic        dmode;
    logic [2:0]  deliv;
    logic [7:0]  vec;
  } redirEntry_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_SEL,
    RD_ID,
    RD_VER,
    RD_ENTRY_LO,
    RD_ENTRY_HI,
    RD_ONES
  } rdSrc_e;

  typedef struct packed {
    logic             idWr;
    logic             entryWrLo;
    logic             entryWrHi;
    logic [IDX_W-1:0] entryIdx;
    rdSrc_e           rdSrc;
  } ctrlStrobe_t;

endpackage

// File: rtl/redir_ctrl.sv
module redir_ctrl
  import redir_pkg::*;
#(
  parameter int             PINS       = 24,
  parameter logic [7:0]     SEL_OFF    = 8'h00,
  parameter logic [7:0]     WIN_OFF    = 8'h10,
  parameter logic [SEL_W-1:0] ID_SEL   = 8'h00,
  parameter logic [SEL_W-1:0] VER_SEL  = 8'h01,
  parameter logic [SEL_W-1:0] ARB_SEL  = 8'h02,
  parameter logic [SEL_W-1:0] ENTRY_BASE = 8'h10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [7:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [SEL_W-1:0] selReg,
  output ctrlStrobe_t      strobe
);

  localparam logic [IDX_W-1:0] PIN_LIMIT = IDX_W'(PINS);

  logic             selAcc;
  logic             winAcc;
  logic             winWr;
  logic             winRd;
  logic [SEL_W-1:0] entryOff;
  logic [IDX_W-1:0] entryIdx;
  logic             inTable;
  logic             upperHalf;

  assign selAcc = busValid && (busAddr == SEL_OFF);
  assign winAcc = busValid && (busAddr == WIN_OFF);
  assign winWr  = winAcc && busWrite;
  assign winRd  = winAcc && !busWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
    end else if (selAcc && busWrite) begin
      selReg <= busWdata[SEL_W-1:0];
    end
  end

  // Entry decode from the select register.
  assign entryOff  = selReg - ENTRY_BASE;
  assign entryIdx  = entryOff[SEL_W-1:1];
  assign upperHalf = selReg[0];
  assign inTable   = (selReg >= ENTRY_BASE) && (entryIdx < PIN_LIMIT);

  always_comb begin
    strobe           = '0;
    strobe.entryIdx  = entryIdx;
    strobe.idWr      = winWr && (selReg == ID_SEL);
    strobe.entryWrLo = winWr && inTable && !upperHalf;
    strobe.entryWrHi = winWr && inTable && upperHalf;
    strobe.rdSrc     = RD_NONE;
    if (selAcc && !busWrite) begin
      strobe.rdSrc = RD_SEL;
    end else if (winRd) begin
      if (selReg == ID_SEL || selReg == ARB_SEL) begin
        strobe.rdSrc = RD_ID;
      end else if (selReg == VER_SEL) begin
        strobe.rdSrc = RD_VER;
      end else if (inTable) begin
        strobe.rdSrc = upperHalf ? RD_ENTRY_HI : RD_ENTRY_LO;
      end else begin
        strobe.rdSrc = RD_ONES;
      end
    end
  end

endmodule

// File: rtl/redir_table.sv
module redir_table
  import redir_pkg::*;
#(
  parameter int         PINS     = 24,
  parameter logic [7:0] VER_CODE = 8'h11,
  parameter int         ID_W     = 4,
  parameter int         ID_LSB   = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [31:0]             busWdata,
  input  logic [SEL_W-1:0]        selReg,
  input  logic [PINS-1:0]         remoteIrrSet,
  output logic [PINS*ENTRY_W-1:0] tableFlat,
  output logic [PINS-1:0]         maskChange,
  output logic [PINS-1:0]         tableWrite,
  output logic [31:0]             busRdata
);

  localparam redirEntry_t ENTRY_RST = '{mask: 1'b1, default: '0};
  localparam logic [7:0]  MAX_PIN   = 8'(PINS - 1);

  redirEntry_t entries [PINS];
  logic [ID_W-1:0] idReg;
  redirEntry_t rdEntry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idReg <= '0;
    end else if (strobe.idWr) begin
      idReg <= busWdata[ID_LSB +: ID_W];
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic        hitLo;
    logic        hitHi;
    redirEntry_t nxt;

    assign hitLo = strobe.entryWrLo && (strobe.entryIdx == IDX_W'(i));
    assign hitHi = strobe.entryWrHi && (strobe.entryIdx == IDX_W'(i));

    always_comb begin
      nxt = entries[i];
      if (hitLo) begin
        nxt[HALF_W-1:0] = busWdata;
        nxt.rirr        = 1'b0;
      end
      if (hitHi) begin
        nxt[ENTRY_W-1:HALF_W] = busWdata;
      end
      if (remoteIrrSet[i] && !hitLo) begin
        nxt.rirr = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entries[i]    <= ENTRY_RST;
        maskChange[i] <= 1'b0;
        tableWrite[i] <= 1'b0;
      end else begin
        entries[i]    <= nxt;
        maskChange[i] <= hitLo && (nxt.mask != entries[i].mask);
        tableWrite[i] <= hitLo || hitHi;
      end
    end

    assign tableFlat[i*ENTRY_W +: ENTRY_W] = entries[i];
  end

  always_comb begin
    rdEntry = '1;
    for (int i = 0; i < PINS; i++) begin
      if (strobe.entryIdx == IDX_W'(i)) rdEntry = entries[i];
    end
  end

  always_comb begin
    busRdata = '0;
    case (strobe.rdSrc)
      RD_SEL:      busRdata = {{(32-SEL_W){1'b0}}, selReg};
      RD_ID:       busRdata[ID_LSB +: ID_W] = idReg;
      RD_VER:      busRdata = {8'h00, MAX_PIN, 8'h00, VER_CODE};
      RD_ENTRY_LO: busRdata = rdEntry[HALF_W-1:0];
      RD_ENTRY_HI: busRdata = rdEntry[ENTRY_W-1:HALF_W];
      RD_ONES:     busRdata = '1;
      default:     busRdata = '0;
    endcase
  end

endmodule

// File: rtl/redir_regfile.sv
module redir_regfile
  import redir_pkg::*;
#(
  parameter int         PINS     = 24,
  parameter logic [7:0] VER_CODE = 8'h11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busValid,
  input  logic                    busWrite,
  input  logic [7:0]              busAddr,
  input  logic [31:0]             busWdata,
  output logic [31:0]             busRdata,
  input  logic [PINS-1:0]         remoteIrrSet,
  output logic [PINS*ENTRY_W-1:0] tableFlat,
  output logic [PINS-1:0]         maskChange,
  output logic [PINS-1:0]         tableWrite
);

  ctrlStrobe_t      strobe;
  logic [SEL_W-1:0] selReg;

  redir_ctrl #(.PINS(PINS)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .selReg   (selReg),
    .strobe   (strobe)
  );

  redir_table #(.PINS(PINS), .VER_CODE(VER_CODE)) i_table (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .busWdata     (busWdata),
    .selReg       (selReg),
    .remoteIrrSet (remoteIrrSet),
    .tableFlat    (tableFlat),
    .maskChange   (maskChange),
    .tableWrite   (tableWrite),
    .busRdata     (busRdata)
  );

endmodule

// File: rtl/redir_checker.sv
module redir_checker #(
  parameter int PINS = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic               busWrite,
  input logic [31:0]        busRdata,
  input logic [PINS-1:0]    remoteIrrSet,
  input logic [PINS*64-1:0] tableFlat,
  input logic [PINS-1:0]    maskChange,
  input logic [PINS-1:0]    tableWrite
);

  a_r10_mask_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(maskChange));

  a_r11_write_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tableWrite));

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |-> (busRdata == 32'h0));

  for (genvar i = 0; i < PINS; i++) begin : g_chk
    a_r10_mask_flipped: assert property (@(posedge clk) disable iff (!rstN)
      maskChange[i] |-> (tableFlat[i*64+16] != $past(tableFlat[i*64+16])));

    a_r10_mask_needs_write: assert property (@(posedge clk) disable iff (!rstN)
      maskChange[i] |-> tableWrite[i]);

    a_r11_quiet_stable: assert property (@(posedge clk) disable iff (!rstN)
      (!tableWrite[i] && !$past(remoteIrrSet[i])) |-> $stable(tableFlat[i*64 +: 64]));
  end

endmodule

bind redir_regfile redir_checker #(.PINS(PINS)) i_redir_checker (
  .clk          (clk),
  .rstN         (rstN),
  .busValid     (busValid),
  .busWrite     (busWrite),
  .busRdata     (busRdata),
  .remoteIrrSet (remoteIrrSet),
  .tableFlat    (tableFlat),
  .maskChange   (maskChange),
  .tableWrite   (tableWrite)
);

// File: tb/test_redir_regfile.sv
module test_redir_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 24;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busValid = 1'b0;
  logic             busWrite = 1'b0;
  logic [7:0]       busAddr = 8'h0;
  logic [31:0]      busWdata = 32'h0;
  logic [31:0]      busRdata;
  logic [NPIN-1:0]  remoteIrrSet = '0;
  logic [NPIN*64-1:0] tableFlat;
  logic [NPIN-1:0]  maskChange;
  logic [NPIN-1:0]  tableWrite;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Reference model state
  logic [63:0]     mEnt [NPIN];
  logic [7:0]      mSel;
  logic [3:0]      mId;
  logic [NPIN-1:0] mMask;
  logic [NPIN-1:0] mTw;

  redir_regfile i_redir_regfile (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .remoteIrrSet(remoteIrrSet), .tableFlat(tableFlat),
    .maskChange(maskChange), .tableWrite(tableWrite)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic modelReset();
    for (int i = 0; i < NPIN; i++) mEnt[i] = 64'h0000_0000_0001_0000;
    mSel = 8'h0; mId = 4'h0; mMask = '0; mTw = '0;
  endtask

  function automatic logic [31:0] modelRead();
    int idx;
    if (!(busValid && !busWrite)) return 32'h0;
    if (busAddr == 8'h00) return {24'h0, mSel};
    if (busAddr != 8'h10) return 32'h0;
    if (mSel == 8'h00 || mSel == 8'h02) return {4'h0, mId, 24'h0};
    if (mSel == 8'h01) return 32'h0017_0011;
    if (mSel < 8'h10) return 32'hFFFF_FFFF;
    idx = (int'(mSel) - 16) / 2;
    if (idx >= NPIN) return 32'hFFFF_FFFF;
    return mSel[0] ? mEnt[idx][63:32] : mEnt[idx][31:0];
  endfunction

  task automatic modelStep();
    int idx;
    int loIdx;
    logic [63:0] oldE, newE;
    loIdx = -1;
    mMask = '0; mTw = '0;
    if (busValid && busWrite && busAddr == 8'h00) begin
      mSel = busWdata[7:0];
    end else if (busValid && busWrite && busAddr == 8'h10) begin
      if (mSel == 8'h00) begin
        mId = busWdata[27:24];
      end else if (mSel >= 8'h10 && ((int'(mSel) - 16) / 2) < NPIN) begin
        idx = (int'(mSel) - 16) / 2;
        oldE = mEnt[idx];
        newE = oldE;
        if (mSel[0]) newE[63:32] = busWdata;
        else begin
          newE[31:0] = busWdata;
          newE[14] = 1'b0;
          loIdx = idx;
        end
        mEnt[idx] = newE;
        mTw[idx] = 1'b1;
        mMask[idx] = (oldE[16] != newE[16]);
      end
    end
    for (int i = 0; i < NPIN; i++)
      if (remoteIrrSet[i] && i != loIdx) mEnt[i][14] = 1'b1;
  endtask

  task automatic compareAll(input string tag);
    logic [31:0] expR;
    vectors++;
    expR = modelRead();
    if (busRdata !== expR) begin
      miscompares++;
      $display("FAIL %s busRdata actual=%h expected=%h", tag, busRdata, expR);
    end
    for (int i = 0; i < NPIN; i++) begin
      if (tableFlat[i*64 +: 64] !== mEnt[i]) begin
        miscompares++;
        $display("FAIL %s entry %0d actual=%h expected=%h", tag, i,
                 tableFlat[i*64 +: 64], mEnt[i]);
      end
    end
    if (maskChange !== mMask) begin
      miscompares++;
      $display("FAIL %s maskChange actual=%h expected=%h", tag, maskChange, mMask);
    end
    if (tableWrite !== mTw) begin
      miscompares++;
      $display("FAIL %s tableWrite actual=%h expected=%h", tag, tableWrite, mTw);
    end
  endtask

  task automatic tick(input logic v, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic [NPIN-1:0] rs,
                      input string tag);
    @(negedge clk);
    busValid = v; busWrite = w; busAddr = a; busWdata = d; remoteIrrSet = rs;
    #1;
    compareAll(tag);
    @(posedge clk);
    if (!rstN) modelReset();
    else modelStep();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    tick(1'b1, 1'b1, a, d, '0, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    tick(1'b1, 1'b0, a, 32'h0, '0, tag);
  endtask

  task automatic idle(input string tag);
    tick(1'b0, 1'b0, 8'h0, 32'h0, '0, tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    modelReset();
    for (int i = 0; i < 3; i++) idle("R1 reset");
    @(negedge clk); rstN = 1'b1;
    idle("R1 after reset");
    rd(8'h00, "R1 select zero");
    rd(8'h10, "R1 id zero");

    // Select register
    wr(8'h00, 32'hABCD_01FF, "R3 select byte");
    rd(8'h00, "R3 select readback");
    rd(8'h10, "R7 select 0xFF ones");

    // Version
    wr(8'h00, 32'h01, "R4 select version");
    rd(8'h10, "R4 version");
    wr(8'h10, 32'hFFFF_FFFF, "R4 version write");
    rd(8'h10, "R4 version unchanged");

    // Identifier and arbitration
    wr(8'h00, 32'h00, "R5 select id");
    wr(8'h10, 32'hF5FF_FFFF, "R5 id write");
    rd(8'h10, "R5 id read");
    wr(8'h00, 32'h02, "R5 select arb");
    rd(8'h10, "R5 arb mirrors id");
    wr(8'h10, 32'h0A00_0000, "R5 arb write ignored");
    rd(8'h10, "R5 arb unchanged");

    // Other offsets
    wr(8'h04, 32'h0000_0033, "R2 stray write");
    rd(8'h00, "R2 select kept");
    rd(8'h04, "R2 stray read");
    rd(8'h20, "R2 stray read 0x20");
    wr(8'h18, 32'h1234_5678, "R2 stray write 0x18");
    rd(8'h10, "R2 window kept");

    // Entry halves
    wr(8'h00, 32'h10, "R6 select entry0 lo");
    wr(8'h10, 32'h0000_4931, "R10 unmask entry0");
    rd(8'h10, "R8 rirr forced low");
    wr(8'h00, 32'h11, "R6 select entry0 hi");
    wr(8'h10, 32'hA700_0000, "R6 entry0 hi write");
    rd(8'h10, "R6 entry0 hi read");
    wr(8'h10, 32'hA700_0000, "R11 same data write");
    wr(8'h00, 32'h3F, "R6 select entry23 hi");
    wr(8'h10, 32'h5500_0001, "R6 entry23 hi write");
    rd(8'h10, "R6 entry23 hi read");
    wr(8'h00, 32'h3E, "R6 select entry23 lo");
    rd(8'h10, "R6 entry23 lo read");
    wr(8'h00, 32'h40, "R7 select index 24");
    rd(8'h10, "R7 out of range ones");
    wr(8'h10, 32'h0, "R7 out of range write");
    wr(8'h00, 32'h05, "R7 select 0x05");
    rd(8'h10, "R7 gap ones");
    wr(8'h10, 32'h0, "R7 gap write");

    // Remote-IRR handling
    tick(1'b0, 1'b0, 8'h0, 32'h0, 24'h00_0003, "R9 set rirr pins 0 1");
    wr(8'h00, 32'h11, "R8 select entry0 hi");
    wr(8'h10, 32'h1100_0000, "R8 hi write keeps rirr");
    wr(8'h00, 32'h10, "R8 select entry0 lo");
    wr(8'h10, 32'h0001_4000, "R8 lo write clears rirr");
    tick(1'b1, 1'b1, 8'h10, 32'h0000_0020, 24'h00_0001, "R9 lo write beats set");
    tick(1'b1, 1'b1, 8'h10, 32'h0000_0020, 24'h00_0002, "R9 set other pin");
    wr(8'h10, 32'h0001_0020, "R10 remask entry0");
    wr(8'h10, 32'h0001_0021, "R10 no mask flip");

    // Mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [7:0] s;
      logic [NPIN-1:0] rs;
      op = int'($urandom_range(0, 9));
      rs = ($urandom_range(0, 7) == 0) ? (NPIN'(1) << $urandom_range(0, NPIN-1)) : '0;
      s = ($urandom_range(0, 15) == 0) ? 8'($urandom()) : 8'($urandom_range(0, 8'h43));
      case (op)
        0, 1:    tick(1'b1, 1'b1, 8'h00, {24'($urandom()), s}, rs, "R6 mixed select");
        2, 3, 4: tick(1'b1, 1'b1, 8'h10, 32'($urandom()), rs, "R6 mixed write");
        5, 6:    tick(1'b1, 1'b0, 8'h10, 32'h0, rs, "R6 mixed read");
        7:       tick(1'b1, 1'b0, 8'h00, 32'h0, rs, "R3 mixed select read");
        8:       tick(1'b1, ($urandom_range(0, 1) == 1), 8'($urandom_range(1, 15)) << 4 | 8'h0F,
                      32'($urandom()), rs, "R2 mixed stray");
        default: tick(1'b0, 1'b0, 8'h00, 32'($urandom()), rs, "R12 mixed idle");
      endcase
    end
    idle("R12 final idle");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule